// File: doc/BRIEF.md
# Reorder Buffer with Register Alias Table

This block keeps the program order of in-flight instructions in an out-of-order core and decides when their results become architectural. Each issued instruction takes the slot at the tail of a circular buffer. Its result arrives later over a single result broadcast bus and is stored in that slot. Results leave the buffer strictly from the head, one per cycle, and only once they have arrived. A committed register result is written into an architected register file held inside the block. A committed store is presented on the commit port so the memory path can perform the write.

Alongside the buffer sits a rename table with one slot per architectural register. A slot either says "the register file holds the current value" or names the buffer slot of the youngest in-flight producer. The issue stage presents two source register numbers together with its allocation request. In the same cycle the block returns, for each source, either a ready value or the tag of the slot it must wait for. A source whose producer has already finished is returned ready, carrying the stored result.

Top module: `rob_rename`

## Requirements
- R1: An accepted allocation receives the slot index shown on `alloc_tag`. Successive accepted allocations receive consecutive indices that wrap from DEPTH-1 to 0.
- R2: `alloc_ready` is low exactly when DEPTH entries are live. While it is low, `alloc_valid` has no effect, and `alloc_tag` stays unchanged on the next cycle.
- R3: A source whose rename slot names a live entry that has not finished shows `srcN_renamed`=1, the slot index on `srcN_tag`, `srcN_ready`=0 and `srcN_value`=0.
- R4: A result broadcast (`cdb_valid`, `cdb_tag`, `cdb_value`) stores the value in the named entry and marks it finished. The value is visible on lookups and on commit from the next cycle.
- R5: `commit_valid` is 1 only when the buffer is non-empty and the head entry has finished. An entry behind an unfinished head never commits, even if it has itself finished. The head advances by one on each commit.
- R6: During a commit, `commit_kind`, `commit_dest` and `commit_value` carry the head entry's fields. Kind encoding: 0 writes a register, 1 is a store, 2 (and 3) produce no result. Only kind 0 updates the architected register file, and the new value is visible from the next cycle.
- R7: When a kind-0 entry commits while its destination's rename slot still names it, that slot reverts to the register file. From the next cycle, lookups of that register show `srcN_renamed`=0, `srcN_ready`=1 and the register-file value.
- R8: When the rename slot of the committing destination names a younger entry, the commit leaves that slot unchanged.
- R9: A source whose rename slot names a finished entry shows `srcN_renamed`=1, `srcN_ready`=1 and that entry's stored value.
- R10: After reset the buffer is empty (`alloc_ready`=1, `alloc_tag`=0, `commit_valid`=0). Every register maps to the register file, and every register-file value is 0.
- R11: Only an accepted kind-0 allocation changes its destination's rename slot, and it points that slot at the new tag. Lookups in the allocation cycle use the mapping from before the allocation, so a source equal to the destination sees the older producer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Issue stage requests a slot |
| alloc_kind | input | 2 | 0 register write, 1 store, 2/3 no result |
| alloc_dest | input | RW | Destination architectural register |
| alloc_src1 | input | RW | First source register to look up |
| alloc_src2 | input | RW | Second source register to look up |
| alloc_ready | output | 1 | A slot is free |
| alloc_tag | output | TW | Slot index given to the next allocation |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TW | Slot the result belongs to |
| cdb_value | input | DW | Result value |
| src1_renamed | output | 1 | First source maps to a buffer slot |
| src1_tag | output | TW | Slot of the first source's producer |
| src1_ready | output | 1 | First source value available |
| src1_value | output | DW | First source value, 0 when not ready |
| src2_renamed | output | 1 | Second source maps to a buffer slot |
| src2_tag | output | TW | Slot of the second source's producer |
| src2_ready | output | 1 | Second source value available |
| src2_value | output | DW | Second source value, 0 when not ready |
| commit_valid | output | 1 | Head entry retires this cycle |
| commit_kind | output | 2 | Kind of the retiring entry |
| commit_dest | output | RW | Destination or store target of the retiring entry |
| commit_value | output | DW | Result of the retiring entry |

## Verification
`alloc_ready`, `alloc_tag`, the source lookups and the commit port are decoded in the same cycle from registered state. Each is therefore compared shortly after the inputs are driven and before the next rising edge. A broadcast, an allocation or a commit changes registered state at the edge that ends its cycle, so its effect is expected exactly one cycle later. The bench keeps a model that is advanced only at that edge, which places every expected change in the cycle after its cause. Directed sequences pin the out-of-order finish, the younger-producer overwrite, the store commit and the full stall to specific cycles. Seeded random traffic then covers the other interleavings.

// File: rtl/rr_pkg.sv
package rr_pkg;

  typedef enum logic [1:0] {
    KIND_REG   = 2'd0,
    KIND_STORE = 2'd1,
    KIND_NONE  = 2'd2,
    KIND_RSVD  = 2'd3
  } rr_kind_e;

endpackage

// File: rtl/rr_arch_regs.sv
module rr_arch_regs #(
  parameter  int NREG = 8,
  parameter  int DW   = 16,
  localparam int RW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [DW-1:0] wr_val,
  input  logic [RW-1:0] rd_idx1,
  input  logic [RW-1:0] rd_idx2,
  output logic [DW-1:0] rd_val1,
  output logic [DW-1:0] rd_val2
);

  logic [NREG-1:0][DW-1:0] regs_q, regs_d;

  always_comb begin
    regs_d = regs_q;
    if (wr_en) regs_d[wr_idx] = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     regs_q <= '0;
    else if (wr_en) regs_q <= regs_d;
  end

  assign rd_val1 = regs_q[rd_idx1];
  assign rd_val2 = regs_q[rd_idx2];

  AST_ARF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R6

endmodule

// File: rtl/rr_alias_table.sv
module rr_alias_table #(
  parameter  int NREG  = 8,
  parameter  int DEPTH = 8,
  localparam int RW    = $clog2(NREG),
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] rd_idx1,
  input  logic [RW-1:0] rd_idx2,
  output logic          rd_busy1,
  output logic [TW-1:0] rd_tag1,
  output logic          rd_busy2,
  output logic [TW-1:0] rd_tag2,
  input  logic          wr_en,
  input  logic [RW-1:0] wr_idx,
  input  logic [TW-1:0] wr_tag,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_idx,
  input  logic [TW-1:0] clr_tag
);

  logic [NREG-1:0] busy_vec;
  logic [TW-1:0]   tag_vec [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_map
    logic          hit_wr, hit_clr, busy_r, busy_n;
    logic [TW-1:0] tag_r, tag_n;

    assign hit_wr  = wr_en && (wr_idx == RW'(i));
    assign hit_clr = clr_en && (clr_idx == RW'(i)) && busy_r && (tag_r == clr_tag);

    // a younger writer in the same cycle wins over the revert
    always_comb begin
      busy_n = busy_r;
      tag_n  = tag_r;
      if (hit_clr) busy_n = 1'b0;
      if (hit_wr) begin
        busy_n = 1'b1;
        tag_n  = wr_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_r <= 1'b0;
        tag_r  <= '0;
      end else if (hit_wr || hit_clr) begin
        busy_r <= busy_n;
        tag_r  <= tag_n;
      end
    end

    assign busy_vec[i] = busy_r;
    assign tag_vec[i]  = tag_r;
  end

  assign rd_busy1 = busy_vec[rd_idx1];
  assign rd_tag1  = tag_vec[rd_idx1];
  assign rd_busy2 = busy_vec[rd_idx2];
  assign rd_tag2  = tag_vec[rd_idx2];

  AST_RAT_REVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && busy_vec[clr_idx] && (tag_vec[clr_idx] == clr_tag) &&
     !(wr_en && (wr_idx == clr_idx)))
    |=> !busy_vec[$past(clr_idx)]); // R7

  AST_RAT_KEEP_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && busy_vec[clr_idx] && (tag_vec[clr_idx] != clr_tag) &&
     !(wr_en && (wr_idx == clr_idx)))
    |=> busy_vec[$past(clr_idx)] &&
        (tag_vec[$past(clr_idx)] == $past(tag_vec[clr_idx]))); // R8

endmodule

// File: rtl/rr_entry_ring.sv
module rr_entry_ring
  import rr_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int DW    = 16,
  parameter  int RW    = 3,
  localparam int TW    = $clog2(DEPTH),
  localparam int PW    = TW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_en,
  input  rr_kind_e      alloc_kind,
  input  logic [RW-1:0] alloc_dest,
  input  logic          cdb_en,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_val,
  input  logic [TW-1:0] rd_tag1,
  input  logic [TW-1:0] rd_tag2,
  output logic          rd_fin1,
  output logic [DW-1:0] rd_val1,
  output logic          rd_fin2,
  output logic [DW-1:0] rd_val2,
  output logic          full,
  output logic [TW-1:0] tail_tag,
  output logic          commit,
  output logic [TW-1:0] head_tag,
  output rr_kind_e      head_kind,
  output logic [RW-1:0] head_dest,
  output logic [DW-1:0] head_val
);

  logic [PW-1:0]    head_q, head_d, tail_q, tail_d;
  logic             empty;
  logic [DEPTH-1:0] fin_vec;
  rr_kind_e         kind_vec [DEPTH];
  logic [RW-1:0]    dest_vec [DEPTH];
  logic [DW-1:0]    val_vec  [DEPTH];

  // wrap bit separates a full ring from an empty one
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[TW] != tail_q[TW]) && (head_q[TW-1:0] == tail_q[TW-1:0]);
  assign head_tag = head_q[TW-1:0];
  assign tail_tag = tail_q[TW-1:0];
  assign commit   = !empty && fin_vec[head_tag];

  always_comb begin
    head_d = head_q + PW'(commit);
    tail_d = tail_q + PW'(alloc_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (commit)   head_q <= head_d;
      if (alloc_en) tail_q <= tail_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic          hit_alloc, hit_cdb, fin_r, fin_n;
    rr_kind_e      kind_r;
    logic [RW-1:0] dest_r;
    logic [DW-1:0] val_r;

    assign hit_alloc = alloc_en && (tail_tag == TW'(i));
    assign hit_cdb   = cdb_en && (cdb_tag == TW'(i));

    always_comb begin
      fin_n = fin_r;
      if (hit_cdb)   fin_n = 1'b1;
      if (hit_alloc) fin_n = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      fin_r <= 1'b0;
      else if (hit_alloc || hit_cdb)   fin_r <= fin_n;
    end

    always_ff @(posedge clk) begin
      if (hit_alloc) begin
        kind_r <= alloc_kind;
        dest_r <= alloc_dest;
      end
    end

    always_ff @(posedge clk) begin
      if (hit_cdb) val_r <= cdb_val;
    end

    assign fin_vec[i]  = fin_r;
    assign kind_vec[i] = kind_r;
    assign dest_vec[i] = dest_r;
    assign val_vec[i]  = val_r;
  end

  assign head_kind = kind_vec[head_tag];
  assign head_dest = dest_vec[head_tag];
  assign head_val  = val_vec[head_tag];
  assign rd_fin1   = fin_vec[rd_tag1];
  assign rd_val1   = val_vec[rd_tag1];
  assign rd_fin2   = fin_vec[rd_tag2];
  assign rd_val2   = val_vec[rd_tag2];

  AST_HEAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (head_q == $past(head_q) + PW'(1))); // R5

  AST_CDB_SETS_FIN: assert property (@(posedge clk) disable iff (!rst_n)
    cdb_en |=> fin_vec[$past(cdb_tag)]); // R4

endmodule

// File: rtl/rob_rename.sv
module rob_rename
  import rr_pkg::*;
#(
  parameter  int DEPTH = 8,
  parameter  int NREG  = 8,
  parameter  int DW    = 16,
  localparam int TW    = $clog2(DEPTH),
  localparam int RW    = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_valid,
  input  logic [1:0]    alloc_kind,
  input  logic [RW-1:0] alloc_dest,
  input  logic [RW-1:0] alloc_src1,
  input  logic [RW-1:0] alloc_src2,
  output logic          alloc_ready,
  output logic [TW-1:0] alloc_tag,
  input  logic          cdb_valid,
  input  logic [TW-1:0] cdb_tag,
  input  logic [DW-1:0] cdb_value,
  output logic          src1_renamed,
  output logic [TW-1:0] src1_tag,
  output logic          src1_ready,
  output logic [DW-1:0] src1_value,
  output logic          src2_renamed,
  output logic [TW-1:0] src2_tag,
  output logic          src2_ready,
  output logic [DW-1:0] src2_value,
  output logic          commit_valid,
  output logic [1:0]    commit_kind,
  output logic [RW-1:0] commit_dest,
  output logic [DW-1:0] commit_value
);

  logic          full, alloc_en, commit, map_wr, map_clr;
  logic          busy1, busy2, fin1, fin2;
  logic [TW-1:0] mtag1, mtag2, head_tag;
  logic [DW-1:0] rob_v1, rob_v2, arf_v1, arf_v2, head_val;
  logic [RW-1:0] head_dest;
  rr_kind_e      kind_in, head_kind;

  assign kind_in  = rr_kind_e'(alloc_kind);
  assign alloc_en = alloc_valid && !full;
  assign map_wr   = alloc_en && (kind_in == KIND_REG);
  assign map_clr  = commit && (head_kind == KIND_REG);

  rr_entry_ring #(.DEPTH(DEPTH), .DW(DW), .RW(RW)) i_ring (
    .clk, .rst_n,
    .alloc_en, .alloc_kind(kind_in), .alloc_dest,
    .cdb_en(cdb_valid), .cdb_tag, .cdb_val(cdb_value),
    .rd_tag1(mtag1), .rd_tag2(mtag2),
    .rd_fin1(fin1), .rd_val1(rob_v1), .rd_fin2(fin2), .rd_val2(rob_v2),
    .full, .tail_tag(alloc_tag), .commit, .head_tag,
    .head_kind, .head_dest, .head_val
  );

  rr_alias_table #(.NREG(NREG), .DEPTH(DEPTH)) i_map (
    .clk, .rst_n,
    .rd_idx1(alloc_src1), .rd_idx2(alloc_src2),
    .rd_busy1(busy1), .rd_tag1(mtag1), .rd_busy2(busy2), .rd_tag2(mtag2),
    .wr_en(map_wr), .wr_idx(alloc_dest), .wr_tag(alloc_tag),
    .clr_en(map_clr), .clr_idx(head_dest), .clr_tag(head_tag)
  );

  rr_arch_regs #(.NREG(NREG), .DW(DW)) i_arf (
    .clk, .rst_n,
    .wr_en(map_clr), .wr_idx(head_dest), .wr_val(head_val),
    .rd_idx1(alloc_src1), .rd_idx2(alloc_src2),
    .rd_val1(arf_v1), .rd_val2(arf_v2)
  );

  always_comb begin
    src1_renamed = busy1;
    src1_tag     = busy1 ? mtag1 : '0;
    src1_ready   = !busy1 || fin1;
    src1_value   = !busy1 ? arf_v1 : (fin1 ? rob_v1 : '0);
    src2_renamed = busy2;
    src2_tag     = busy2 ? mtag2 : '0;
    src2_ready   = !busy2 || fin2;
    src2_value   = !busy2 ? arf_v2 : (fin2 ? rob_v2 : '0);
  end

  assign alloc_ready  = !full;
  assign commit_valid = commit;
  assign commit_kind  = head_kind;
  assign commit_dest  = head_dest;
  assign commit_value = head_val;

  AST_STALL_HOLDS_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready) |=> (alloc_tag == $past(alloc_tag))); // R2

endmodule

// File: tb/test_rob_rename.sv
module test_rob_rename;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [1:0]  alloc_kind = '0;
  logic [2:0]  alloc_dest = '0, alloc_src1 = '0, alloc_src2 = '0;
  logic        alloc_ready;
  logic [2:0]  alloc_tag;
  logic        cdb_valid = 1'b0;
  logic [2:0]  cdb_tag = '0;
  logic [15:0] cdb_value = '0;
  logic        src1_renamed, src1_ready, src2_renamed, src2_ready;
  logic [2:0]  src1_tag, src2_tag;
  logic [15:0] src1_value, src2_value;
  logic        commit_valid;
  logic [1:0]  commit_kind;
  logic [2:0]  commit_dest;
  logic [15:0] commit_value;

  rob_rename i_rob_rename (.*);

  always #10 clk = ~clk;

  int n_tests = 0, n_fail = 0;

  // reference state, advanced only at the rising edge
  logic [1:0]  m_kind [8];
  logic [2:0]  m_dest [8];
  logic [15:0] m_val  [8];
  bit          m_fin  [8];
  bit          m_busy [8];
  int          m_tag  [8];
  logic [15:0] m_arf  [8];
  int          mh = 0, mt = 0;

  // last sampled outputs, for directed checks
  bit          o_ren1, o_rdy1, o_cv, o_ar;
  logic [2:0]  o_tag1, o_atag, o_cdest;
  logic [15:0] o_val1, o_cval;
  logic [1:0]  o_ckind;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit av, logic [1:0] ak, logic [2:0] ad, logic [2:0] a1,
                      logic [2:0] a2, bit cv, logic [2:0] ct, logic [15:0] cval);
    int cnt, h, t, s, mtg;
    bit full, ecv, acc;
    alloc_valid = av; alloc_kind = ak; alloc_dest = ad;
    alloc_src1 = a1; alloc_src2 = a2;
    cdb_valid = cv; cdb_tag = ct; cdb_value = cval;
    #2;
    cnt  = (mt - mh + 16) % 16;
    full = (cnt == 8);
    h = mh % 8; t = mt % 8;
    ecv = (cnt != 0) && m_fin[h];
    o_ar = alloc_ready; o_atag = alloc_tag;
    o_ren1 = src1_renamed; o_rdy1 = src1_ready; o_tag1 = src1_tag; o_val1 = src1_value;
    o_cv = commit_valid; o_ckind = commit_kind; o_cdest = commit_dest; o_cval = commit_value;
    chk("R2", "alloc_ready", alloc_ready, !full);
    chk("R1", "alloc_tag", alloc_tag, t);
    for (int k = 0; k < 2; k++) begin
      bit          ren, rdy;
      logic [2:0]  tg;
      logic [15:0] vl;
      s   = (k == 0) ? a1 : a2;
      ren = (k == 0) ? src1_renamed : src2_renamed;
      rdy = (k == 0) ? src1_ready : src2_ready;
      tg  = (k == 0) ? src1_tag : src2_tag;
      vl  = (k == 0) ? src1_value : src2_value;
      if (!m_busy[s]) begin
        chk("R7", "lookup renamed", ren, 0);
        chk("R7", "lookup ready", rdy, 1);
        chk("R7", "lookup arf value", vl, m_arf[s]);
      end else begin
        mtg = m_tag[s];
        chk("R3", "lookup renamed", ren, 1);
        chk("R3", "lookup tag", tg, mtg);
        if (m_fin[mtg]) begin
          chk("R9", "lookup ready", rdy, 1);
          chk("R9", "lookup rob value", vl, m_val[mtg]);
        end else begin
          chk("R3", "lookup ready", rdy, 0);
          chk("R3", "lookup value", vl, 0);
        end
      end
    end
    chk("R5", "commit_valid", commit_valid, ecv);
    if (ecv) begin
      chk("R6", "commit_kind", commit_kind, m_kind[h]);
      chk("R6", "commit_dest", commit_dest, m_dest[h]);
      chk("R6", "commit_value", commit_value, m_val[h]);
    end
    acc = av && !full;
    @(posedge clk);
    if (cv) begin m_val[ct] = cval; m_fin[ct] = 1; end
    if (ecv) begin
      if (m_kind[h] == 2'd0) begin
        m_arf[m_dest[h]] = m_val[h];
        if (m_busy[m_dest[h]] && m_tag[m_dest[h]] == h) m_busy[m_dest[h]] = 0;
      end
      mh = (mh + 1) % 16;
    end
    if (acc) begin
      m_kind[t] = ak; m_dest[t] = ad; m_fin[t] = 0;
      if (ak == 2'd0) begin m_busy[ad] = 1; m_tag[ad] = t; end
      mt = (mt + 1) % 16;
    end
    @(negedge clk);
  endtask

  task automatic idle(logic [2:0] a1);
    step(0, 0, 0, a1, a1, 0, 0, 0);
  endtask

  initial begin : watchdog
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int seed_init;
    seed_init = $urandom(32'h1F2E);
    for (int i = 0; i < 8; i++) begin
      m_fin[i] = 0; m_busy[i] = 0; m_tag[i] = 0; m_arf[i] = '0;
      m_val[i] = '0; m_kind[i] = '0; m_dest[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    idle(1);
    chk("R10", "reset ready", o_ar, 1);
    chk("R10", "reset tag", o_atag, 0);
    chk("R10", "reset commit", o_cv, 0);
    chk("R10", "reset lookup", {o_ren1, o_rdy1, o_val1}, {1'b0, 1'b1, 16'h0});

    // R11 same-cycle lookup sees the older mapping
    step(1, 0, 1, 1, 1, 0, 0, 0);
    chk("R11", "src==dest old mapping", o_ren1, 0);
    step(0, 0, 0, 1, 1, 1, 0, 16'h1111);
    chk("R3", "pending tag0", {o_ren1, o_rdy1, o_tag1}, {1'b1, 1'b0, 3'd0});
    idle(1);
    chk("R4", "finished value next cycle", {o_rdy1, o_val1}, {1'b1, 16'h1111});
    chk("R5", "head commits", o_cv, 1);
    idle(1);
    chk("R7", "reverted to arf", {o_ren1, o_val1}, {1'b0, 16'h1111});

    // R8 younger producer keeps the mapping
    step(1, 0, 2, 0, 0, 0, 0, 0);
    step(1, 0, 2, 0, 0, 0, 0, 0);
    step(0, 0, 0, 2, 2, 1, 1, 16'h2222);
    idle(2);
    idle(2);
    chk("R8", "younger mapping kept", {o_ren1, o_tag1, o_rdy1}, {1'b1, 3'd2, 1'b0});

    // R5 in-order retirement despite out-of-order finish
    step(1, 0, 3, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 3, 16'h3333);
    idle(0);
    chk("R5", "no commit past unfinished head", o_cv, 0);
    step(0, 0, 0, 0, 0, 1, 2, 16'h2220);
    idle(0);
    chk("R6", "commit tag2", {o_cv, o_cdest, o_cval}, {1'b1, 3'd2, 16'h2220});
    idle(0);
    chk("R6", "commit tag3", {o_cv, o_cdest, o_cval}, {1'b1, 3'd3, 16'h3333});
    idle(2);
    chk("R7", "arf after in-order commit", {o_ren1, o_val1}, {1'b0, 16'h2220});

    // R6 store commit leaves the register file alone
    step(1, 1, 3, 3, 3, 0, 0, 0);
    step(0, 0, 0, 3, 3, 1, 4, 16'hBEEF);
    chk("R11", "store does not rename", o_ren1, 0);
    idle(3);
    chk("R6", "store commit", {o_cv, o_ckind, o_cdest, o_cval}, {1'b1, 2'd1, 3'd3, 16'hBEEF});
    idle(3);
    chk("R6", "arf kept after store", {o_ren1, o_val1}, {1'b0, 16'h3333});

    // R2 full buffer stall, tail index wraps (R1)
    for (int k = 0; k < 8; k++) step(1, 0, 3'(k), 0, 0, 0, 0, 0);
    step(1, 0, 5, 0, 0, 0, 0, 0);
    chk("R2", "full not ready", o_ar, 0);
    chk("R1", "tail wrapped to 5", o_atag, 5);
    idle(0);
    chk("R2", "tag unchanged after stalled request", o_atag, 5);
    for (int k = 7; k >= 0; k--) step(0, 0, 0, 0, 0, 1, 3'((5 + k) % 8), 16'(16'h4000 + k));
    repeat (10) idle(0);

    // seeded random traffic
    for (int n = 0; n < 3000; n++) begin
      int cand [8];
      int nc, cnt, r;
      bit cv;
      logic [2:0] ct;
      logic [1:0] ak;
      nc = 0;
      cnt = (mt - mh + 16) % 16;
      for (int i = 0; i < cnt; i++) begin
        int idx;
        idx = (mh + i) % 8;
        if (!m_fin[idx]) begin cand[nc] = idx; nc++; end
      end
      cv = (nc > 0) && ($urandom % 10 < 7);
      ct = cv ? 3'(cand[$urandom % nc]) : 3'd0;
      r  = $urandom % 4;
      ak = (r < 2) ? 2'd0 : (r == 2) ? 2'd1 : 2'd2;
      step(($urandom % 4) != 0, ak, 3'($urandom), 3'($urandom), 3'($urandom),
           cv, ct, 16'($urandom));
    end
    while (mh != mt) begin
      int idx;
      idx = mh % 8;
      if (!m_fin[idx]) step(0, 0, 0, 0, 1, 1, 3'(idx), 16'h5A5A);
      else idle(0);
    end
    for (int r = 0; r < 8; r++) idle(3'(r));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule